// File: doc/BRIEF.md
# Pixel Array Exposure Sequencer

This block times the exposure of an image sensor pixel array. A rising edge on the frame trigger starts a frame. The block first drives a global reset, which holds every pixel in reset at the same time. It then opens the main integration window. If enabled, two further slope phases follow, and each one is a short reset pulse followed by its own integration window. When the last active phase closes, the block returns to idle and raises a one-cycle done flag.

All durations come from 16-bit length inputs. One mode input selects the time base. In line mode, a duration counts line-start strobes. In cycle mode, it counts clock cycles. The lengths, the mode and the slope enables are captured when a frame starts, so software can prepare the next frame's settings while the current frame runs. While the enable input is low, the block stays idle and drives no phase output. Readout, conversion control and windowing belong to other blocks.

Top module: `pix_expo_seq`

## Requirements
- R1: A rising edge of `frame_trig` while `seq_en` is high and the block is idle starts a frame. `arr_rst` goes high in the cycle after that edge and stays high for `len_rst` ticks.
- R2: When `line_mode` is 0, one tick is one clock cycle. When `line_mode` is 1, a tick is one clock cycle in which `line_strb` is high, and the phase counter does not move in any other cycle.
- R3: Phases run in this fixed order: global reset, main integration, second-slope reset, second-slope integration, third-slope reset, third-slope integration. Each phase starts in the cycle right after the previous one ends. While a phase is active, it drives `arr_rst` for the global reset, `slope_rst` for either slope reset, or `integ` for any integration.
- R4: The second-slope phases run only if `dual_en` was 1 when the frame started. Its reset pulse lasts `len_srst` ticks and its integration lasts `len_int2` ticks.
- R5: The third-slope phases run only if `triple_en` was 1 when the frame started. Its reset pulse lasts `len_srst` ticks and its integration lasts `len_int3` ticks.
- R6: A phase whose length is zero is skipped and produces no output cycle.
- R7: `done` is high for exactly one cycle: the first idle cycle after the last active phase. If every phase is skipped, that cycle is the one right after the trigger edge.
- R8: The lengths, `line_mode`, `dual_en` and `triple_en` are sampled when the frame starts. Changing them during a frame does not affect that frame.
- R9: While `seq_en` is low, the block returns to idle in the next cycle, with no phase output and no `done`, and it ignores triggers. A trigger edge during a running frame is also ignored.
- R10: At most one of `arr_rst`, `slope_rst` and `integ` is high in any cycle, and all are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Sequencer enable |
| frame_trig | input | 1 | Frame start; acts on its rising edge |
| line_strb | input | 1 | One-cycle line-start strobe |
| line_mode | input | 1 | 1: lengths count line strobes; 0: clock cycles |
| dual_en | input | 1 | Enable second-slope phases |
| triple_en | input | 1 | Enable third-slope phases |
| len_rst | input | CNT_W | Global reset length |
| len_srst | input | CNT_W | Slope reset pulse length |
| len_int | input | CNT_W | Main integration length |
| len_int2 | input | CNT_W | Second-slope integration length |
| len_int3 | input | CNT_W | Third-slope integration length |
| arr_rst | output | 1 | Global pixel reset |
| slope_rst | output | 1 | Slope reset pulse |
| integ | output | 1 | Integration window |
| done | output | 1 | Frame complete, one cycle |

## Verification
The bench builds the block with the default counter width of 16 bits. It programs lengths of at most nine ticks, so every phase, and every skip of a zero-length phase, can be seen cycle by cycle inside a short run. Line mode is driven with a strobe every fifth cycle, which makes stalled counting between strobes visible next to cycle-mode timing. The full 16-bit range only changes how far the counter runs, and it is carried by the same compare.

// File: rtl/pix_expo_seq.sv
module pix_expo_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_en,
  input  logic             frame_trig,
  input  logic             line_strb,
  input  logic             line_mode,
  input  logic             dual_en,
  input  logic             triple_en,
  input  logic [CNT_W-1:0] len_rst,
  input  logic [CNT_W-1:0] len_srst,
  input  logic [CNT_W-1:0] len_int,
  input  logic [CNT_W-1:0] len_int2,
  input  logic [CNT_W-1:0] len_int3,
  output logic             arr_rst,
  output logic             slope_rst,
  output logic             integ,
  output logic             done
);

  typedef enum logic [2:0] {
    S_IDLE, S_GRST, S_INT1, S_SRST2, S_INT2, S_SRST3, S_INT3
  } st_t;

  st_t              st, nxt_run, nxt_start;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_in [0:7];
  logic [CNT_W-1:0] len_q  [0:7];
  logic [7:0]       el_in, el_q;
  logic             mode_q, trig_q, done_q;

  wire trig_rise = frame_trig & ~trig_q;
  wire tick      = mode_q ? line_strb : 1'b1;

  assign len_in[0] = '0;
  assign len_in[1] = len_rst;
  assign len_in[2] = len_int;
  assign len_in[3] = dual_en   ? len_srst : '0;
  assign len_in[4] = dual_en   ? len_int2 : '0;
  assign len_in[5] = triple_en ? len_srst : '0;
  assign len_in[6] = triple_en ? len_int3 : '0;
  assign len_in[7] = '0;

  for (genvar k = 0; k < 8; k++) begin : g_el
    assign el_in[k] = |len_in[k];
    assign el_q[k]  = |len_q[k];
  end

  function automatic st_t after(input logic [2:0] from, input logic [7:0] el);
    st_t r = S_IDLE;
    logic hit = 1'b0;
    for (int k = 1; k < 7; k++)
      if (!hit && k > int'(from) && el[k]) begin
        r   = st_t'(k);
        hit = 1'b1;
      end
    return r;
  endfunction

  assign nxt_run   = after(st, el_q);
  assign nxt_start = after(3'd0, el_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      mode_q <= 1'b0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
      for (int k = 0; k < 8; k++) len_q[k] <= '0;
    end else begin
      trig_q <= frame_trig;
      done_q <= 1'b0;
      if (!seq_en) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (st == S_IDLE) begin
        if (trig_rise) begin
          for (int k = 0; k < 8; k++) len_q[k] <= len_in[k];
          mode_q <= line_mode;
          cnt    <= '0;
          st     <= nxt_start;
          done_q <= (nxt_start == S_IDLE);
        end
      end else if (tick) begin
        if (cnt + 1'b1 == len_q[st]) begin
          cnt    <= '0;
          st     <= nxt_run;
          done_q <= (nxt_run == S_IDLE);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign arr_rst   = (st == S_GRST);
  assign slope_rst = (st == S_SRST2) || (st == S_SRST3);
  assign integ     = (st == S_INT1) || (st == S_INT2) || (st == S_INT3);
  assign done      = done_q;

  a_r1_reset_follows_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && st == S_IDLE && trig_rise && len_rst != '0) |=> arr_rst);

  a_r2_line_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && mode_q && !line_strb && st != S_IDLE) |=> ($stable(st) && $stable(cnt)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!arr_rst && !slope_rst && !integ));

  a_r8_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && seq_en) |=> ($stable(mode_q) && $stable(len_q[2]) && $stable(len_q[4])));

  a_r9_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_en |=> (!arr_rst && !slope_rst && !integ && !done));

  a_r10_one_phase_output: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_rst, slope_rst, integ}));

endmodule

// File: tb/pix_expo_seq_tb_top.sv
`timescale 1ns/1ps
module pix_expo_seq_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seq_en = 1'b0, frame_trig = 1'b0, line_strb = 1'b0, line_mode = 1'b0;
  logic dual_en = 1'b0, triple_en = 1'b0;
  logic [CNT_W-1:0] len_rst = '0, len_srst = '0, len_int = '0, len_int2 = '0, len_int3 = '0;
  logic arr_rst, slope_rst, integ, done;

  int checks = 0, fails = 0;
  int exp_c [0:7];
  int exp_n [0:7];
  int n_exp = 0;
  bit strb_on = 1'b0;
  int ccnt = 0;

  always #2 clk = ~clk;

  pix_expo_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .frame_trig(frame_trig),
    .line_strb(line_strb), .line_mode(line_mode), .dual_en(dual_en),
    .triple_en(triple_en), .len_rst(len_rst), .len_srst(len_srst),
    .len_int(len_int), .len_int2(len_int2), .len_int3(len_int3),
    .arr_rst(arr_rst), .slope_rst(slope_rst), .integ(integ), .done(done));

  always @(posedge clk) begin
    #1;
    ccnt++;
    line_strb = strb_on && (ccnt % 5 == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int code();
    return arr_rst ? 1 : slope_rst ? 2 : integ ? 3 : 0;
  endfunction

  task automatic set_len(input int r, input int s, input int i1, input int i2, input int i3);
    len_rst = CNT_W'(r); len_srst = CNT_W'(s); len_int = CNT_W'(i1);
    len_int2 = CNT_W'(i2); len_int3 = CNT_W'(i3);
  endtask

  task automatic add_exp(input int c, input int n);
    exp_c[n_exp] = c; exp_n[n_exp] = n; n_exp++;
  endtask

  task automatic run_frame(input string req, input bit lm, input bit mid);
    int rc [0:15];
    int rn [0:15];
    int nr = 0, prev = 0, cur;
    bit ended = 1'b0;
    @(negedge clk) frame_trig = 1'b1;
    @(negedge clk) frame_trig = 1'b0;
    for (int i = 0; i < 400 && !ended; i++) begin
      cur = code();
      if (cur == 0) begin
        chk({req, " R7 done on first idle cycle"}, int'(done), 1);
        ended = 1'b1;
      end else begin
        if (cur != prev && nr < 16) begin rc[nr] = cur; rn[nr] = 0; nr++; end
        if (nr > 0) rn[nr-1] += lm ? int'(line_strb) : 1;
        prev = cur;
        if (mid && i == 1) begin
          set_len(1, 1, 9, 9, 9); line_mode = 1'b1; frame_trig = 1'b1;
        end
        if (mid && i == 2) frame_trig = 1'b0;
        @(negedge clk);
      end
    end
    if (!ended) chk({req, " frame timeout"}, 0, 1);
    @(negedge clk);
    chk({req, " R7 done lasts one cycle"}, int'(done), 0);
    chk({req, " R3 phase count"}, nr, n_exp);
    for (int k = 0; k < n_exp && k < nr; k++) begin
      chk({req, " R3 phase output"}, rc[k], exp_c[k]);
      chk({req, " phase length"}, rn[k], exp_n[k]);
    end
  endtask

  task automatic t_reset();
    chk("R10 reset arr_rst", int'(arr_rst), 0);
    chk("R10 reset slope_rst", int'(slope_rst), 0);
    chk("R10 reset integ", int'(integ), 0);
    chk("R7 reset done", int'(done), 0);
  endtask

  task automatic t_all_phases();
    line_mode = 0; dual_en = 1; triple_en = 1; set_len(3, 2, 5, 4, 6);
    n_exp = 0; add_exp(1, 3); add_exp(3, 5); add_exp(2, 2); add_exp(3, 4); add_exp(2, 2); add_exp(3, 6);
    run_frame("R1 R4 R5 all phases", 0, 0);
  endtask

  task automatic t_dual_only();
    dual_en = 1; triple_en = 0; set_len(2, 3, 4, 1, 7);
    n_exp = 0; add_exp(1, 2); add_exp(3, 4); add_exp(2, 3); add_exp(3, 1);
    run_frame("R4 dual only", 0, 0);
  endtask

  task automatic t_triple_only();
    dual_en = 0; triple_en = 1; set_len(1, 2, 3, 8, 2);
    n_exp = 0; add_exp(1, 1); add_exp(3, 3); add_exp(2, 2); add_exp(3, 2);
    run_frame("R5 triple only", 0, 0);
  endtask

  task automatic t_zero_skip();
    dual_en = 1; triple_en = 0; set_len(0, 2, 5, 0, 0);
    n_exp = 0; add_exp(3, 5); add_exp(2, 2);
    run_frame("R6 zero skip", 0, 0);
  endtask

  task automatic t_all_zero();
    dual_en = 1; triple_en = 1; set_len(0, 0, 0, 0, 0);
    n_exp = 0;
    run_frame("R6 R7 all zero", 0, 0);
  endtask

  task automatic t_line_mode();
    strb_on = 1; line_mode = 1; dual_en = 0; triple_en = 0; set_len(2, 0, 3, 0, 0);
    n_exp = 0; add_exp(1, 2); add_exp(3, 3);
    run_frame("R2 line mode", 1, 0);
    strb_on = 0; line_mode = 0;
  endtask

  task automatic t_mid_change();
    dual_en = 0; triple_en = 0; set_len(3, 0, 5, 0, 0);
    n_exp = 0; add_exp(1, 3); add_exp(3, 5);
    run_frame("R8 R9 mid-frame change and retrigger", 0, 1);
    line_mode = 0;
  endtask

  task automatic t_disable();
    dual_en = 0; triple_en = 0; set_len(6, 0, 4, 0, 0);
    @(negedge clk) frame_trig = 1'b1;
    @(negedge clk) frame_trig = 1'b0;
    chk("R1 reset active before disable", int'(arr_rst), 1);
    @(negedge clk) seq_en = 1'b0;
    @(negedge clk);
    chk("R9 disabled outputs idle", code(), 0);
    chk("R9 disabled no done", int'(done), 0);
    frame_trig = 1'b1;
    @(negedge clk) frame_trig = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 trigger ignored while disabled", code(), 0);
    end
    seq_en = 1'b1;
    @(negedge clk);
    set_len(2, 0, 2, 0, 0);
    n_exp = 0; add_exp(1, 2); add_exp(3, 2);
    run_frame("R9 recovery after enable", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; seq_en = 1'b1;
    @(negedge clk);
    t_all_phases();
    t_dual_only();
    t_triple_only();
    t_zero_skip();
    t_all_zero();
    t_line_mode();
    t_mid_change();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule